// File: doc/BRIEF.md
# Pre/Post Trigger Stream Capture

This block sits beside a valid/ready beat stream and records beats into a local buffer, in the manner of an embedded logic analyzer. It never drives the stream. Software arms it with a mode bit and a post-trigger length. In triggered mode the buffer runs as a ring that always holds the newest beats. When the trigger input asserts, the block stores the requested number of further beats and then freezes, so the capture holds traffic from both sides of the event.

In continuous mode there is no trigger. The buffer behaves as a plain first-in first-out store: beats fill it, and reads drain it.

A processor reads everything through a small read port with four registers: state, trigger position, fill count and a data window. Each beat is split into 32-bit words. Repeated reads of the data window walk from the oldest stored beat to the newest, low word first.

Top module: `stream_capture`

## Requirements
- R1: After reset the state code is 0 (idle) and the fill count is 0. A one-cycle `arm` pulse empties the buffer, clears the trigger position and enters state 1 (pre-trigger) when `use_trig` is 1, or state 4 (continuous) when it is 0.
- R2: A beat is recorded only in a cycle where `tap_valid` and `tap_ready` are both high. The block has no output toward the monitored stream.
- R3: In state 1 the buffer is a ring of DEPTH entries. Once it is full, each new beat replaces the oldest one, so it holds the most recent DEPTH beats and the fill count never exceeds DEPTH.
- R4: A trigger seen in state 1 takes effect after the beat accepted in that same cycle, which counts as pre-trigger. The trigger position register (address 1) gives the readout index of the first post-trigger beat. It is lowered by one each time a post-trigger beat overwrites a pre-trigger entry.
- R5: After a trigger, the block stores `post_beats` more beats (taken at arm time and limited to DEPTH), then moves to state 3. While in state 3 it raises `done` and records nothing. With `post_beats` equal to 0 it enters state 3 right at the trigger. `done` stays high until the next arm.
- R6: Trigger pulses in states 2 (post-trigger) and 3 change neither the post-trigger length, the trigger position nor the stored beats.
- R7: In state 4 beats are stored while the buffer has room. A beat arriving while the buffer is full is dropped. Reads free space for later beats.
- R8: A read of address 3 returns a 32-bit word of the oldest stored beat: bits 31:0 first, then each next 32-bit slice. A read that takes the beat's last word removes the beat. The read only has an effect in states 3 and 4 with a non-empty buffer; otherwise address 3 returns 0 and nothing changes.
- R9: Address 0 returns the state code in bits 2:0 with zeros above, and address 2 returns the fill count. Reading these has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_valid | input | 1 | Valid of the monitored stream |
| tap_ready | input | 1 | Ready of the monitored stream (observed only) |
| tap_data | input | DATA_W | Data of the monitored stream |
| trig | input | 1 | Trigger event |
| arm | input | 1 | Start a new capture (one-cycle pulse) |
| use_trig | input | 1 | Mode taken at arm: 1 triggered, 0 continuous |
| post_beats | input | AW+1 | Post-trigger beat count taken at arm |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Register select |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| done | output | 1 | Capture complete |

## Verification
The bench builds the block with DEPTH 8 and 64-bit beats, so every beat is read as two words. This small depth lets it sweep every pre-trigger length from 0 to 11 against every post-trigger length from 0 to 8. That covers partial windows, a ring that has wrapped, post-trigger beats that push out pre-trigger history, and a zero-length tail. The trigger is placed both on the last pre-trigger beat and on an idle cycle. Stall cycles with ready low are mixed in, and extra trigger pulses arrive during and after the tail. Further short runs cover the clamp on the post-trigger length, reads attempted while capture is live, and continuous mode running into a full buffer and draining.

// File: rtl/stream_capture.sv
module stream_capture #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_valid,
  input  logic              tap_ready,
  input  logic [DATA_W-1:0] tap_data,
  input  logic              trig,
  input  logic              arm,
  input  logic              use_trig,
  input  logic [AW:0]       post_beats,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  output logic [31:0]       reg_rdata,
  output logic              done
);
  localparam int WPB = DATA_W / 32;
  localparam int WSW = (WPB > 1) ? $clog2(WPB) : 1;
  localparam logic [AW:0] FULL_N = (AW+1)'(DEPTH);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_PRE = 3'd1, S_POST = 3'd2, S_DONE = 3'd3, S_CONT = 3'd4
  } st_t;

  st_t               st;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       cnt, cnt_nx, tpos, left;
  logic [WSW-1:0]    wsel;
  logic [31:0]       word;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  wire beat     = tap_valid & tap_ready;
  wire full     = (cnt == FULL_N);
  wire empty    = (cnt == '0);
  wire readable = (st == S_DONE || st == S_CONT) && !empty;
  wire rd_data  = reg_rd && reg_addr == 2'd3 && readable;
  wire pop      = rd_data && wsel == WSW'(WPB-1);
  wire wr       = beat && (st == S_PRE || st == S_POST || (st == S_CONT && !full));
  wire drop_old = wr && full && st != S_CONT;

  assign cnt_nx = cnt + (AW+1)'(wr && !drop_old) - (AW+1)'(pop);
  assign word   = mem[rp][32*int'(wsel) +: 32];
  assign done   = (st == S_DONE);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {29'b0, st};
      2'd1:    reg_rdata = 32'(tpos);
      2'd2:    reg_rdata = 32'(cnt);
      default: reg_rdata = readable ? word : 32'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (wr) mem[wp] <= tap_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      tpos <= '0;
      left <= '0;
      wsel <= '0;
    end else if (arm) begin
      st   <= use_trig ? S_PRE : S_CONT;
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      tpos <= '0;
      wsel <= '0;
      left <= (post_beats > FULL_N) ? FULL_N : post_beats;
    end else begin
      if (wr) wp <= inc(wp);
      if (drop_old || pop) rp <= inc(rp);
      cnt <= cnt_nx;
      if (rd_data) wsel <= pop ? '0 : wsel + 1'b1;
      case (st)
        S_PRE:
          if (trig) begin
            tpos <= cnt_nx;
            st   <= (left == '0) ? S_DONE : S_POST;
          end
        S_POST:
          if (wr) begin
            left <= left - 1'b1;
            if (left == (AW+1)'(1)) st <= S_DONE;
            if (drop_old && tpos != '0) tpos <= tpos - 1'b1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/capture_checks.sv
module capture_checks #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
)(
  input logic        clk,
  input logic        rst_n,
  input logic        arm,
  input logic        trig,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic [2:0]  st,
  input logic [AW:0] cnt,
  input logic [AW:0] tpos,
  input logic        done
);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  assert_arm_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cnt == '0 && tpos == '0));

  assert_idle_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> (cnt == '0));

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  assert_trigpos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2) |-> (tpos <= cnt));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm && !(reg_rd && reg_addr == 2'd3)) |=> ($stable(cnt) && $stable(tpos)));

  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && trig && !arm) |=> (st == 3'd2 || st == 3'd3));
endmodule

bind stream_capture capture_checks #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .st(st), .cnt(cnt), .tpos(tpos), .done(done)
);

// File: tb/stream_capture_test.sv
module stream_capture_test;
  localparam int DW = 64;
  localparam int D  = 8;
  localparam int AW = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic tap_valid = 0, tap_ready = 0, trig = 0, arm = 0, use_trig = 0, reg_rd = 0;
  logic [DW-1:0] tap_data = '0;
  logic [AW:0] post_beats = '0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_rdata;
  logic done;
  int checks = 0, fails = 0;
  bit ended = 0;

  stream_capture #(.DATA_W(DW), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .tap_valid(tap_valid), .tap_ready(tap_ready),
    .tap_data(tap_data), .trig(trig), .arm(arm), .use_trig(use_trig),
    .post_beats(post_beats), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .done(done));

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] beatv(input int k);
    return {32'h1000_0000 + 32'(k*3 + 7), 32'hA5A5_0000 ^ 32'(k)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic step(input logic v, input logic r, input int k, input logic t);
    @(negedge clk);
    tap_valid = v; tap_ready = r; tap_data = beatv(k); trig = t;
    @(posedge clk); #1;
    tap_valid = 0; tap_ready = 0; trig = 0;
  endtask

  task automatic rreg(input logic [1:0] a, input logic strobe, output logic [31:0] val);
    @(negedge clk);
    reg_addr = a; reg_rd = strobe;
    #1 val = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic do_arm(input logic mode, input int post);
    @(negedge clk);
    arm = 1; use_trig = mode; post_beats = (AW+1)'(post);
    @(posedge clk); #1;
    arm = 0;
  endtask

  task automatic drain(input string tag, input int first, input int n);
    logic [31:0] v;
    for (int j = 0; j < n; j++) begin
      logic [DW-1:0] e;
      e = beatv(first + j);
      rreg(2'd3, 1'b1, v); chk({tag, " R8 low word"}, v, e[31:0]);
      rreg(2'd3, 1'b1, v); chk({tag, " R8 high word"}, v, e[63:32]);
    end
    rreg(2'd3, 1'b1, v); chk({tag, " R8 empty read"}, v, 32'h0);
    rreg(2'd2, 1'b0, v); chk({tag, " R9 count after drain"}, v, 32'h0);
  endtask

  task automatic run_trig(input int p, input int post, input int n_eff);
    logic [31:0] v;
    int pre, all, stored, ov, k;
    do_arm(1'b1, post);
    rreg(2'd0, 1'b0, v); chk("R1 armed state", v, 32'd1);
    k = 0;
    for (int i = 0; i < p; i++) begin
      if (i % 3 == 2) step(1'b1, 1'b0, 999, 1'b0);
      step(1'b1, 1'b1, k, (p % 2 == 1) && (i == p-1));
      k++;
    end
    if (p % 2 == 0) step(1'b0, 1'b0, 0, 1'b1);
    for (int i = 0; i < n_eff + 2; i++) begin
      if (i == 1) step(1'b0, 1'b1, 998, 1'b0);
      step(1'b1, 1'b1, k, i == 0 || i == n_eff);
      if (i < n_eff) k++;
    end
    step(1'b0, 1'b0, 0, 1'b1);
    pre = (p < D) ? p : D;
    all = pre + n_eff;
    stored = (all < D) ? all : D;
    ov = all - stored;
    rreg(2'd0, 1'b0, v); chk("R5 done state", v, 32'd3);
    chk("R5 done flag", 32'(done), 32'd1);
    rreg(2'd2, 1'b0, v); chk("R3 R6 stored count", v, 32'(stored));
    rreg(2'd1, 1'b0, v); chk("R4 trigger position", v, 32'(pre - ov));
    drain("R2 R3 trig run", p + n_eff - stored, stored);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rreg(2'd0, 1'b0, v); chk("R1 reset state", v, 32'd0);
    rreg(2'd2, 1'b0, v); chk("R1 reset count", v, 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);

    for (int p = 0; p < 12; p++)
      for (int n = 0; n <= D; n++)
        run_trig(p, n, n);
    run_trig(5, 13, D);

    // R8: data reads while capture is live have no effect
    do_arm(1'b1, 2);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, i, 1'b0);
    rreg(2'd3, 1'b1, v); chk("R8 read while pre", v, 32'h0);
    rreg(2'd2, 1'b0, v); chk("R8 count kept while pre", v, 32'd3);
    step(1'b0, 1'b0, 0, 1'b1);
    rreg(2'd3, 1'b1, v); chk("R8 read while post", v, 32'h0);
    step(1'b1, 1'b1, 3, 1'b0);
    step(1'b1, 1'b1, 4, 1'b0);
    chk("R5 done after tail", 32'(done), 32'd1);
    drain("R8 live run", 0, 5);

    // R7: continuous mode
    do_arm(1'b0, 0);
    rreg(2'd0, 1'b0, v); chk("R7 continuous state", v, 32'd4);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, i, i == 4);
    step(1'b1, 1'b0, 50, 1'b0);
    rreg(2'd2, 1'b0, v); chk("R7 full count", v, 32'(D));
    chk("R7 no done", 32'(done), 32'd0);
    for (int j = 0; j < 3; j++) begin
      logic [DW-1:0] e;
      e = beatv(j);
      rreg(2'd3, 1'b1, v); chk("R7 R8 low word", v, e[31:0]);
      rreg(2'd3, 1'b1, v); chk("R7 R8 high word", v, e[63:32]);
    end
    step(1'b1, 1'b1, 20, 1'b0);
    step(1'b1, 1'b1, 21, 1'b0);
    rreg(2'd2, 1'b0, v); chk("R7 count after refill", v, 32'(D - 1));
    for (int j = 3; j < 8; j++) begin
      logic [DW-1:0] e;
      e = beatv(j);
      rreg(2'd3, 1'b1, v); chk("R7 kept low", v, e[31:0]);
      rreg(2'd3, 1'b1, v); chk("R7 kept high", v, e[63:32]);
    end
    drain("R7 refill", 20, 2);
    summary();
  end
endmodule